// File: doc/BRIEF.md
# Map-Gated Defective Pixel Corrector

This block repairs known-bad sensor pixels in a raster video stream. It takes two AXI4-Stream inputs. One carries pixel values. The other carries one flag bit per pixel that marks the pixel as defective. The block consumes the two inputs in lockstep. Each joined beat is written into a small ring of row stores, and the block walks its own output raster over those rows.

For a flagged pixel, the output is built only from the four diagonal neighbours. Each diagonal pair along a row is averaged, and the two averages are then averaged. Every average rounds half up. An unflagged pixel passes through unchanged, and so does every pixel while bypass is held high. At the frame border, a neighbour coordinate outside the frame is replaced by the nearest coordinate inside it.

Frame width and height come from configuration inputs. They must be held stable while a frame is in flight. Input beats are grouped into frames by counting. The output stream marks the first pixel of each frame on TUSER and the last pixel of each row on TLAST.

Top module: `defect_pixel_fixer`

## Requirements
- R1: A pixel beat and a flag beat are always consumed together. `s_px_tready` is high only while `s_map_tvalid` is high, and `s_map_tready` is high only while `s_px_tvalid` is high. Over any run, the number of accepted pixel beats equals the number of accepted flag beats.
- R2: When the flag bit (`s_map_tdata` = 1) of an interior pixel is set and bypass is low, the output is `(T + B + 1) >> 1`. Here `T = (NW + NE + 1) >> 1` and `B = (SW + SE + 1) >> 1`, using the diagonal neighbours of that pixel.
- R3: When the flag bit is 0, the output equals the input pixel at the same position.
- R4: When `cfg_bypass` is 1, every output equals the input pixel at the same position, whatever the flag bits are.
- R5: For a flagged pixel on the frame border, row -1 is read as row 0 and row `cfg_rows` as row `cfg_rows`-1. Column -1 is read as column 0 and column `cfg_cols` as column `cfg_cols`-1. The formula of R2 is applied to those clamped neighbours.
- R6: Each frame produces exactly `cfg_rows`×`cfg_cols` output beats, in raster order. `m_tuser` is 1 only on the beat at row 0, column 0. `m_tlast` is 1 exactly on column `cfg_cols`-1. No output is valid after reset until input arrives.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values into the next cycle.
- R8: Suppose the output register is free. The first output beat of a frame then becomes valid one clock after the edge at which the input beat at row 1, column 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | 9 | Active columns per row (1..MAX_COLS) |
| cfg_rows | input | 8 | Rows per frame (1..MAX_ROWS) |
| cfg_bypass | input | 1 | 1 forces every pixel through uncorrected |
| s_px_tvalid | input | 1 | Pixel stream valid |
| s_px_tready | output | 1 | Pixel stream ready |
| s_px_tdata | input | 8 | Pixel value |
| s_map_tvalid | input | 1 | Flag stream valid |
| s_map_tready | output | 1 | Flag stream ready |
| s_map_tdata | input | 1 | 1 marks the matching pixel as defective |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | 8 | Corrected pixel |
| m_tuser | output | 1 | First pixel of a frame |
| m_tlast | output | 1 | Last pixel of a row |

## Verification
Replacement at a border pixel and an output stall can fall in the same cycle. In that cycle the clamped diagonal fetch must not disturb the word being held for the stalled consumer. The bench provokes this by throttling `m_tready` on a two-in-three pattern while flags sit on edge and corner pixels. It also pauses the two input streams on different rhythms. Every held beat is compared with the beat seen one cycle earlier, and every delivered beat is compared with an independently computed expected value, so a corrupted stall or a wrong clamp both show up as a mismatch.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    // read taps into the row store
    localparam int TAP_NW = 0;
    localparam int TAP_NE = 1;
    localparam int TAP_SW = 2;
    localparam int TAP_SE = 3;
    localparam int TAP_C  = 4;
    localparam int NTAPS  = 5;
    // ring of row slots, indexed by low row bits
    localparam int SLOT_W = 2;
    localparam int SLOTS  = 1 << SLOT_W;
endpackage

// File: rtl/dpc_stream_join.sv
module dpc_stream_join (
    input  logic px_valid,
    input  logic map_valid,
    input  logic space,
    output logic px_ready,
    output logic map_ready,
    output logic fire
);
    // each side is offered ready only when its partner is present
    always_comb begin
        px_ready  = space && map_valid;
        map_ready = space && px_valid;
        fire      = space && px_valid && map_valid;
    end
endmodule

// File: rtl/dpc_row_store.sv
module dpc_row_store
    import dpc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int MAX_COLS = 320,
    parameter int CW       = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [CW-1:0]     wr_col,
    input  logic [DW-1:0]     wr_pix,
    input  logic              wr_flag,
    input  logic [SLOT_W-1:0] rd_slot [NTAPS],
    input  logic [CW-1:0]     rd_col  [NTAPS],
    output logic [DW-1:0]     rd_pix  [NTAPS],
    output logic              rd_flag
);
    localparam int AW = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;

    logic [DW-1:0] pix_mem  [SLOTS][MAX_COLS];
    logic          flag_mem [SLOTS][MAX_COLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pix_mem[wr_slot][wr_col[AW-1:0]]  <= wr_pix;
            flag_mem[wr_slot][wr_col[AW-1:0]] <= wr_flag;
        end
    end

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        assign rd_pix[t] = pix_mem[rd_slot[t]][rd_col[t][AW-1:0]];
    end

    assign rd_flag = flag_mem[rd_slot[TAP_C]][rd_col[TAP_C][AW-1:0]];
endmodule

// File: rtl/dpc_bilinear.sv
module dpc_bilinear #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] nw,
    input  logic [DW-1:0] ne,
    input  logic [DW-1:0] sw,
    input  logic [DW-1:0] se,
    input  logic [DW-1:0] ctr,
    input  logic          replace,
    output logic [DW-1:0] pix
);
    logic [DW:0]   top_sum, bot_sum, mid_sum;
    logic [DW-1:0] top_avg, bot_avg, lo_v, hi_v;

    always_comb begin
        top_sum = {1'b0, nw} + {1'b0, ne} + (DW+1)'(1);
        bot_sum = {1'b0, sw} + {1'b0, se} + (DW+1)'(1);
        top_avg = top_sum[DW:1];
        bot_avg = bot_sum[DW:1];
        mid_sum = {1'b0, top_avg} + {1'b0, bot_avg} + (DW+1)'(1);
        pix     = replace ? mid_sum[DW:1] : ctr;
    end

    // the rounded blend never leaves the span of its four inputs
    always_comb begin
        lo_v = nw;
        hi_v = nw;
        if (ne < lo_v) lo_v = ne;
        if (sw < lo_v) lo_v = sw;
        if (se < lo_v) lo_v = se;
        if (ne > hi_v) hi_v = ne;
        if (sw > hi_v) hi_v = sw;
        if (se > hi_v) hi_v = se;
        if (replace) begin
            assert_interp_span_R2: assert (pix >= lo_v && pix <= hi_v)
                else $error("interpolated value outside diagonal span");
        end
    end
endmodule

// File: rtl/defect_pixel_fixer.sv
module defect_pixel_fixer
    import dpc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int MAX_COLS = 320,
    parameter int MAX_ROWS = 240,
    localparam int CW      = $clog2(MAX_COLS + 1),
    localparam int RW      = $clog2(MAX_ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_cols,
    input  logic [RW-1:0] cfg_rows,
    input  logic          cfg_bypass,
    input  logic          s_px_tvalid,
    output logic          s_px_tready,
    input  logic [DW-1:0] s_px_tdata,
    input  logic          s_map_tvalid,
    output logic          s_map_tready,
    input  logic          s_map_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic [DW-1:0] m_tdata,
    output logic          m_tuser,
    output logic          m_tlast
);
    localparam int RX = RW + 1;

    typedef struct packed {
        logic [RW-1:0] in_row;
        logic [CW-1:0] in_col;
        logic [RW-1:0] o_row;
        logic [CW-1:0] o_col;
        logic          vld;
        logic [DW-1:0] data;
        logic          user;
        logic          last;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [RW-1:0]     row_up, row_dn, row_last;
    logic [CW-1:0]     col_lf, col_rt, col_last;
    logic              space, fire, avail, emit;
    logic [SLOT_W-1:0] tap_slot [NTAPS];
    logic [CW-1:0]     tap_col  [NTAPS];
    logic [DW-1:0]     tap_pix  [NTAPS];
    logic              ctr_flag;
    logic [DW-1:0]     fixed_pix;

    // neighbourhood coordinates with border clamping
    always_comb begin
        row_last = cfg_rows - RW'(1);
        col_last = cfg_cols - CW'(1);
        row_up   = (seq_q.o_row == '0) ? '0 : seq_q.o_row - RW'(1);
        row_dn   = (seq_q.o_row < row_last) ? seq_q.o_row + RW'(1) : row_last;
        col_lf   = (seq_q.o_col == '0) ? '0 : seq_q.o_col - CW'(1);
        col_rt   = (seq_q.o_col < col_last) ? seq_q.o_col + CW'(1) : col_last;

        tap_slot[TAP_NW] = row_up[SLOT_W-1:0];       tap_col[TAP_NW] = col_lf;
        tap_slot[TAP_NE] = row_up[SLOT_W-1:0];       tap_col[TAP_NE] = col_rt;
        tap_slot[TAP_SW] = row_dn[SLOT_W-1:0];       tap_col[TAP_SW] = col_lf;
        tap_slot[TAP_SE] = row_dn[SLOT_W-1:0];       tap_col[TAP_SE] = col_rt;
        tap_slot[TAP_C]  = seq_q.o_row[SLOT_W-1:0];  tap_col[TAP_C]  = seq_q.o_col;

        // input may run at most two rows ahead of the output row
        space = (seq_q.in_row < cfg_rows) &&
                ({1'b0, seq_q.in_row} <= ({1'b0, seq_q.o_row} + RX'(2)));
        // the furthest tap needed has been written
        avail = (seq_q.in_row > row_dn) ||
                ((seq_q.in_row == row_dn) && (seq_q.in_col > col_rt));
        emit  = avail && (!seq_q.vld || m_tready);
    end

    dpc_stream_join u_join (
        .px_valid  (s_px_tvalid),
        .map_valid (s_map_tvalid),
        .space     (space),
        .px_ready  (s_px_tready),
        .map_ready (s_map_tready),
        .fire      (fire)
    );

    dpc_row_store #(.DW(DW), .MAX_COLS(MAX_COLS), .CW(CW)) u_store (
        .clk     (clk),
        .wr_en   (fire),
        .wr_slot (seq_q.in_row[SLOT_W-1:0]),
        .wr_col  (seq_q.in_col),
        .wr_pix  (s_px_tdata),
        .wr_flag (s_map_tdata),
        .rd_slot (tap_slot),
        .rd_col  (tap_col),
        .rd_pix  (tap_pix),
        .rd_flag (ctr_flag)
    );

    dpc_bilinear #(.DW(DW)) u_interp (
        .nw      (tap_pix[TAP_NW]),
        .ne      (tap_pix[TAP_NE]),
        .sw      (tap_pix[TAP_SW]),
        .se      (tap_pix[TAP_SE]),
        .ctr     (tap_pix[TAP_C]),
        .replace (ctr_flag && !cfg_bypass),
        .pix     (fixed_pix)
    );

    always_comb begin
        seq_d = seq_q;
        if (fire) begin
            if (seq_q.in_col == col_last) begin
                seq_d.in_col = '0;
                seq_d.in_row = seq_q.in_row + RW'(1);
            end else begin
                seq_d.in_col = seq_q.in_col + CW'(1);
            end
        end
        if (emit) begin
            seq_d.vld  = 1'b1;
            seq_d.data = fixed_pix;
            seq_d.user = (seq_q.o_row == '0) && (seq_q.o_col == '0);
            seq_d.last = (seq_q.o_col == col_last);
            if (seq_q.o_col == col_last) begin
                seq_d.o_col = '0;
                if (seq_q.o_row == row_last) begin
                    seq_d.o_row  = '0;
                    seq_d.in_row = '0;
                    seq_d.in_col = '0;
                end else begin
                    seq_d.o_row = seq_q.o_row + RW'(1);
                end
            end else begin
                seq_d.o_col = seq_q.o_col + CW'(1);
            end
        end else if (m_tready) begin
            seq_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign m_tvalid = seq_q.vld;
    assign m_tdata  = seq_q.data;
    assign m_tuser  = seq_q.user;
    assign m_tlast  = seq_q.last;

    assert_join_lockstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_px_tvalid && s_px_tready) |-> (s_map_tvalid && s_map_tready))
        else $error("pixel consumed without its flag");

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
                                     $stable(m_tuser) && $stable(m_tlast)))
        else $error("output changed while stalled");

    assert_sof_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(m_tvalid && m_tready && !m_tlast) && m_tvalid) |-> !m_tuser)
        else $error("frame start flagged mid-row");
endmodule

// File: tb/defect_pixel_fixer_bench.sv
module defect_pixel_fixer_bench;
    localparam int DW = 8;
    localparam int CW = 9;
    localparam int RW = 8;
    localparam int WATCHDOG = 100000;

    // {flag, pixel} for a 4x5 frame in raster order
    localparam logic [8:0] TBL_A [20] = '{
        {1'b1, 8'd10},  {1'b0, 8'd20},  {1'b0, 8'd30},  {1'b0, 8'd40},  {1'b0, 8'd50},
        {1'b0, 8'd15},  {1'b0, 8'd200}, {1'b1, 8'd35},  {1'b0, 8'd45},  {1'b0, 8'd55},
        {1'b1, 8'd90},  {1'b0, 8'd80},  {1'b0, 8'd70},  {1'b0, 8'd61},  {1'b0, 8'd3},
        {1'b0, 8'd255}, {1'b0, 8'd128}, {1'b1, 8'd0},   {1'b0, 8'd77},  {1'b1, 8'd99}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] cfg_cols;
    logic [RW-1:0] cfg_rows;
    logic          cfg_bypass;
    logic          s_px_tvalid, s_px_tready;
    logic [DW-1:0] s_px_tdata;
    logic          s_map_tvalid, s_map_tready, s_map_tdata;
    logic          m_tvalid, m_tready, m_tuser, m_tlast;
    logic [DW-1:0] m_tdata;

    always #2 clk = ~clk;

    defect_pixel_fixer u_defect_pixel_fixer (
        .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_bypass(cfg_bypass),
        .s_px_tvalid(s_px_tvalid), .s_px_tready(s_px_tready), .s_px_tdata(s_px_tdata),
        .s_map_tvalid(s_map_tvalid), .s_map_tready(s_map_tready), .s_map_tdata(s_map_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    int checks = 0, errors = 0, cyc = 0;
    int img [8][8];
    bit flg [8][8];
    int rows = 1, cols = 1;
    bit byp = 0;
    int exp_idx = 0, acc = 0, acc_cyc = 0;
    bit lat_check = 0, seen_first = 1, hold_pend = 0, mon_en = 0;
    int held_data;
    bit held_user, held_last;
    int px_tot = 0, map_tot = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int expv, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int clampi(int v, int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    function automatic int expect_pix(int r, int c);
        int ru, rd, cl, cr, t, b;
        if (byp || !flg[r][c]) return img[r][c];
        ru = clampi(r - 1, rows - 1); rd = clampi(r + 1, rows - 1);
        cl = clampi(c - 1, cols - 1); cr = clampi(c + 1, cols - 1);
        t = (img[ru][cl] + img[ru][cr] + 1) >> 1;
        b = (img[rd][cl] + img[rd][cr] + 1) >> 1;
        return (t + b + 1) >> 1;
    endfunction

    always @(negedge clk) begin
        if (mon_en) begin
            if (s_px_tready)  chk(s_map_tvalid == 1'b1, "R1", 0, 1, "pixel ready without flag valid");
            if (s_map_tready) chk(s_px_tvalid == 1'b1, "R1", 0, 1, "flag ready without pixel valid");
            if (s_px_tvalid && s_px_tready) begin
                px_tot++; acc++;
                if (acc == cols + 2) acc_cyc = cyc;
            end
            if (s_map_tvalid && s_map_tready) map_tot++;
            if (hold_pend)
                chk(m_tvalid && (int'(m_tdata) == held_data) && m_tuser == held_user &&
                    m_tlast == held_last, "R7", int'(m_tdata), held_data, "stalled beat changed");
            hold_pend = m_tvalid && !m_tready;
            held_data = int'(m_tdata); held_user = m_tuser; held_last = m_tlast;
            if (m_tvalid && !seen_first) begin
                seen_first = 1;
                if (lat_check) chk(cyc - acc_cyc == 2, "R8", cyc - acc_cyc, 2, "first output delay");
            end
            if (m_tvalid && m_tready) begin
                if (exp_idx >= rows * cols) begin
                    chk(0, "R6", exp_idx, rows * cols, "extra output beat");
                end else begin
                    int r, c, e;
                    string req;
                    r = exp_idx / cols; c = exp_idx % cols;
                    e = expect_pix(r, c);
                    if (byp) req = "R4";
                    else if (!flg[r][c]) req = "R3";
                    else if (r == 0 || c == 0 || r == rows - 1 || c == cols - 1) req = "R5";
                    else req = "R2";
                    chk(int'(m_tdata) == e, req, int'(m_tdata), e, $sformatf("pixel r%0d c%0d", r, c));
                    chk(m_tuser == (exp_idx == 0), "R6", int'(m_tuser), int'(exp_idx == 0), "tuser");
                    chk(m_tlast == (c == cols - 1), "R6", int'(m_tlast), int'(c == cols - 1), "tlast");
                end
                exp_idx++;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive_px(bit gap);
        bit ok;
        for (int i = 0; i < rows * cols; i++) begin
            if (gap && (i % 3 == 1)) begin
                s_px_tvalid = 1'b0;
                @(posedge clk); #1;
            end
            s_px_tvalid = 1'b1;
            s_px_tdata  = DW'(img[i / cols][i % cols]);
            do begin
                @(negedge clk); ok = s_px_tready;
                @(posedge clk); #1;
            end while (!ok);
        end
        s_px_tvalid = 1'b0;
    endtask

    task automatic drive_map(bit gap);
        bit ok;
        for (int i = 0; i < rows * cols; i++) begin
            if (gap && (i % 4 == 2)) begin
                s_map_tvalid = 1'b0;
                repeat (2) begin @(posedge clk); #1; end
            end
            s_map_tvalid = 1'b1;
            s_map_tdata  = flg[i / cols][i % cols];
            do begin
                @(negedge clk); ok = s_map_tready;
                @(posedge clk); #1;
            end while (!ok);
        end
        s_map_tvalid = 1'b0;
    endtask

    task automatic drive_rdy(bit throttle);
        while (exp_idx < rows * cols) begin
            m_tready = throttle ? ((cyc % 3) != 0) : 1'b1;
            @(posedge clk); #1;
        end
        m_tready = 1'b1;
    endtask

    task automatic run_frame(int r, int c, bit b, bit pgap, bit mgap, bit thr, bit lat);
        rows = r; cols = c; byp = b;
        cfg_rows = RW'(r); cfg_cols = CW'(c); cfg_bypass = b;
        exp_idx = 0; acc = 0; seen_first = 0; lat_check = lat;
        fork
            drive_px(pgap);
            drive_map(mgap);
            drive_rdy(thr);
        join
        repeat (6) begin
            @(negedge clk);
            chk(!m_tvalid, "R6", int'(m_tvalid), 0, "valid after frame end");
        end
        @(posedge clk); #1;
    endtask

    task automatic load_table(bit all_flag);
        for (int i = 0; i < 20; i++) begin
            img[i / 5][i % 5] = int'(TBL_A[i][7:0]);
            flg[i / 5][i % 5] = all_flag ? 1'b1 : TBL_A[i][8];
        end
    endtask

    initial begin
        rst_n = 1'b0; cfg_cols = CW'(5); cfg_rows = RW'(4); cfg_bypass = 1'b0;
        s_px_tvalid = 1'b0; s_px_tdata = '0; s_map_tvalid = 1'b0; s_map_tdata = 1'b0;
        m_tready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_tvalid, "R6", int'(m_tvalid), 0, "valid in reset");
        chk(!s_px_tready, "R1", int'(s_px_tready), 0, "pixel ready in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        mon_en = 1'b1;
        @(negedge clk);
        chk(!m_tvalid, "R6", int'(m_tvalid), 0, "valid before input");
        @(posedge clk); #1;

        // table-driven frame, continuous flow, latency measured (R2 R3 R5 R8)
        load_table(1'b0);
        run_frame(4, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        // computed pattern, uneven input gaps, throttled output (R1 R5 R7)
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 7; c++) begin
                img[r][c] = (r * 53 + c * 29 + 7) % 256;
                flg[r][c] = ((r + c) % 3 == 0);
            end
        run_frame(6, 7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

        // every flag set but bypass high (R4)
        load_table(1'b1);
        run_frame(4, 5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

        // narrow frame with extreme values, all flagged: rounding and clamping (R2 R5)
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 2; c++) begin
                img[r][c] = ((r + c) % 2 == 1) ? 255 : 254;
                flg[r][c] = 1'b1;
            end
        img[2][1] = 0;
        run_frame(3, 2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // single-row frame, all flagged (R5)
        img[0][0] = 9; img[0][1] = 100; img[0][2] = 201;
        for (int c = 0; c < 3; c++) flg[0][c] = 1'b1;
        run_frame(1, 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        // same table frame again after other sizes, latency again (R8 R3)
        load_table(1'b0);
        run_frame(4, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        chk(px_tot == map_tot, "R1", px_tot, map_tot, "accepted beat totals");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule